// File: doc/BRIEF.md
# Up/Down Timer Counter with Selectable Upper Limit

This block is the counting core of an 8-bit timer. The count rises, or rises and then falls, by one on each enabled tick. The upper limit (TOP) is either the fixed all-ones value or a value that software writes into a compare register. In single-slope mode the count climbs to TOP and then restarts from zero. In dual-slope mode it climbs to TOP, turns, falls to zero and turns again. The direction is kept inside the block.

A sticky overflow flag records each completed period. In single-slope mode the period ends at the step from TOP to zero. In dual-slope mode it ends when the falling count reaches zero. The flag, gated by an enable bit, drives the interrupt request. Ticks come from a prescaler enable pulse in the system clock domain, or from an external oscillator tick. The external tick is synchronised and edge-detected first. Software reads and writes the count, the compare value and a control/status word through a small register port.

Top module: `updown_tmr`

## Requirements
- R1: After reset the count, the compare value, the overflow flag and the interrupt enable are zero, `irq` is 0, and the direction is up.
- R2: With `mode`=00 (single-slope, TOP fixed at 0xFF), each enabled tick adds one. A tick at 0xFF gives 0x00 and sets the overflow flag.
- R3: With `mode`=01 (single-slope, TOP from the compare register), a tick while the count equals the compare value gives 0x00 and sets the overflow flag.
- R4: With `mode[1]`=1 (dual-slope, `mode[0]` picks TOP as in R2/R3), a tick at TOP while rising turns the count downward by one. A tick while falling subtracts one, and the step from 1 to 0 sets the overflow flag. A tick at 0 while falling turns the count upward by one. Single-slope mode always counts up.
- R5: `at_top` is 1 exactly when the count equals the selected TOP. `at_bottom` is 1 exactly when the count is 0x00.
- R6: In a cycle with no enabled tick, no count write and no clear, the count holds.
- R7: Within one cycle a register write to the count (address 0) has priority over `tmr_clr`, and `tmr_clr` has priority over a tick. A clear sets the count to 0x00 and the direction to up.
- R8: The overflow flag (address 2, bit 0) stays set until a write to address 2 with bit 0 = 1 clears it. If a flag-setting step and that clear fall in the same cycle, the flag ends up set.
- R9: `irq` equals the overflow flag ANDed with the interrupt enable, which is address 2, bit 1 (read/write).
- R10: With `src_sel`=1, `presc_tick` is ignored. Each rising edge of `ext_tick` gives one step, and the count changes at the third rising `clk` edge after `ext_tick` goes high (two-stage synchroniser plus edge detection).
- R11: If TOP is set below the count while counting up, the count keeps rising through 0xFF. It steps to 0x00 there without setting the flag, and only then meets TOP again.
- R12: `reg_rdata` shows the register at `reg_addr` without a clock delay: 0 = count, 1 = compare value, 2 = {interrupt enable, overflow flag} in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 count, 1 compare, 2 control/status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| mode | input | 2 | Bit 0: TOP from the compare register; bit 1: dual-slope |
| src_sel | input | 1 | 0: prescaler tick, 1: external oscillator tick |
| presc_tick | input | 1 | Count enable pulse from the prescaler |
| ext_tick | input | 1 | Asynchronous external oscillator tick |
| tmr_clr | input | 1 | Clear the count |
| cnt | output | 8 | Current count |
| at_top | output | 1 | Count equals the selected TOP |
| at_bottom | output | 1 | Count equals zero |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two pairs of actions can fall in the same cycle. A step that sets the overflow flag can meet a software write that clears it. A count write can meet a clear and a tick. The bench drives the TOP-reaching tick together with a write of 1 to flag bit 0, then reads address 2 and expects the flag still set. It also drives a count write, a clear and a tick all in one cycle and expects the written value, then a clear and a tick together and expects zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CNT = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTL = 2'd2;

    localparam int CTL_FLAG_BIT = 0;
    localparam int CTL_IE_BIT   = 1;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic presc_tick,
    input  logic ext_tick,
    output logic step
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } tick_t;

    tick_t q, d;
    logic  ext_edge;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], ext_tick};
        d.last = q.sync[SYNC_STAGES-1];
    end

    assign ext_edge = q.sync[SYNC_STAGES-1] & ~q.last;
    assign step     = src_sel ? ext_edge : presc_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10: an external edge yields a single-cycle step only
    p_ext_one_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel && ext_edge) |=> !ext_edge);
endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         clr,
    input  logic         dual,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt,
    output logic         at_top,
    output logic         at_bottom,
    output logic         ovf_evt
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        dir_e         dir;
    } core_t;

    core_t q, d;

    assign at_top    = (q.cnt == top_val);
    assign at_bottom = (q.cnt == '0);

    always_comb begin
        d       = q;
        ovf_evt = 1'b0;
        if (ld) begin
            d.cnt = ld_val;
        end else if (clr) begin
            d.cnt = '0;
            d.dir = DIR_UP;
        end else if (step) begin
            if (!dual) begin
                if (at_top) begin
                    d.cnt   = '0;
                    ovf_evt = 1'b1;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end else if (q.dir == DIR_UP) begin
                if (at_top) begin
                    d.dir = DIR_DN;
                    if (!at_bottom) begin
                        d.cnt   = q.cnt - ONE;
                        ovf_evt = (q.cnt == ONE);
                    end
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end else begin
                if (at_bottom) begin
                    d.dir = DIR_UP;
                    if (!at_top) d.cnt = q.cnt + ONE;
                end else begin
                    d.cnt   = q.cnt - ONE;
                    ovf_evt = (q.cnt == ONE);
                end
            end
        end
        if (!dual) d.dir = DIR_UP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, dir: DIR_UP};
        else        q <= d;
    end

    assign cnt = q.cnt;

    // R6: idle cycle keeps the count
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld && !clr) |=> (q.cnt == $past(q.cnt)));

    // R7: a count write always lands
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q.cnt == $past(ld_val)));

    // R7: clear beats a tick
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ld) |=> (q.cnt == '0));

    // R2: single-slope below TOP rises by one
    p_single_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual && step && !ld && !clr && !at_top) |=> (q.cnt == $past(q.cnt) + ONE));

    // R3: single-slope at TOP restarts from zero
    p_single_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual && step && !ld && !clr && at_top) |=> (q.cnt == '0));

    // R4: dual-slope moves by at most one
    p_dual_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dual && step && !ld && !clr) |=>
        ((q.cnt == $past(q.cnt) + ONE) || (q.cnt == $past(q.cnt) - ONE) ||
         (q.cnt == $past(q.cnt))));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      cnt,
    input  logic              ovf_evt,
    output logic [W-1:0]      cmp,
    output logic              ld,
    output logic [W-1:0]      rdata,
    output logic              irq
);
    typedef struct packed {
        logic [W-1:0] cmp;
        logic         ie;
        logic         flag;
    } regs_t;

    regs_t q, d;
    logic  flag_wclr;

    assign ld        = wr && (addr == A_CNT);
    assign flag_wclr = wr && (addr == A_CTL) && wdata[CTL_FLAG_BIT];

    always_comb begin
        d = q;
        if (wr && addr == A_CMP) d.cmp = wdata;
        if (wr && addr == A_CTL) d.ie  = wdata[CTL_IE_BIT];
        if (flag_wclr)           d.flag = 1'b0;
        if (ovf_evt)             d.flag = 1'b1;
    end

    always_comb begin
        case (addr)
            A_CNT:   rdata = cnt;
            A_CMP:   rdata = q.cmp;
            A_CTL:   rdata = W'({q.ie, q.flag});
            default: rdata = '0;
        endcase
    end

    assign cmp = q.cmp;
    assign irq = q.flag & q.ie;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: flag survives unless explicitly cleared
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !flag_wclr) |=> q.flag);

    // R8: an overflow event always leaves the flag set
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> q.flag);

    // R9: request stays low while the flag is clear
    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.flag && !ovf_evt) |=> !irq);
endmodule

// File: rtl/updown_tmr.sv
module updown_tmr
    import tmr_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic [1:0]        mode,
    input  logic              src_sel,
    input  logic              presc_tick,
    input  logic              ext_tick,
    input  logic              tmr_clr,
    output logic [W-1:0]      cnt,
    output logic              at_top,
    output logic              at_bottom,
    output logic              irq
);
    localparam logic [W-1:0] MAX_VAL = '1;

    logic         step;
    logic         ld;
    logic         ovf_evt;
    logic [W-1:0] cmp;
    logic [W-1:0] top_val;

    assign top_val = mode[0] ? cmp : MAX_VAL;

    tmr_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (src_sel),
        .presc_tick (presc_tick),
        .ext_tick   (ext_tick),
        .step       (step)
    );

    tmr_cnt_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .ld        (ld),
        .ld_val    (reg_wdata),
        .clr       (tmr_clr),
        .dual      (mode[1]),
        .top_val   (top_val),
        .cnt       (cnt),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .ovf_evt   (ovf_evt)
    );

    tmr_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .cnt     (cnt),
        .ovf_evt (ovf_evt),
        .cmp     (cmp),
        .ld      (ld),
        .rdata   (reg_rdata),
        .irq     (irq)
    );
endmodule

// File: tb/sim_updown_tmr.sv
module sim_updown_tmr;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 28;

    // {mode[1:0], op[2:0], data[7:0], exp_cnt[7:0], exp_flag, pad[1:0]}
    // op: 0 tick, 1 write count, 2 clear, 3 write compare, 4 clear flag
    localparam logic [23:0] VEC [0:NV-1] = '{
        {2'd0, 3'd1, 8'hFD, 8'hFD, 1'b0, 2'b0},
        {2'd0, 3'd0, 8'h00, 8'hFE, 1'b0, 2'b0},
        {2'd0, 3'd0, 8'h00, 8'hFF, 1'b0, 2'b0},
        {2'd0, 3'd0, 8'h00, 8'h00, 1'b1, 2'b0},
        {2'd0, 3'd4, 8'h00, 8'h00, 1'b0, 2'b0},
        {2'd0, 3'd3, 8'h03, 8'h00, 1'b0, 2'b0},
        {2'd1, 3'd0, 8'h00, 8'h01, 1'b0, 2'b0},
        {2'd1, 3'd0, 8'h00, 8'h02, 1'b0, 2'b0},
        {2'd1, 3'd0, 8'h00, 8'h03, 1'b0, 2'b0},
        {2'd1, 3'd0, 8'h00, 8'h00, 1'b1, 2'b0},
        {2'd1, 3'd4, 8'h00, 8'h00, 1'b0, 2'b0},
        {2'd3, 3'd0, 8'h00, 8'h01, 1'b0, 2'b0},
        {2'd3, 3'd0, 8'h00, 8'h02, 1'b0, 2'b0},
        {2'd3, 3'd0, 8'h00, 8'h03, 1'b0, 2'b0},
        {2'd3, 3'd0, 8'h00, 8'h02, 1'b0, 2'b0},
        {2'd3, 3'd0, 8'h00, 8'h01, 1'b0, 2'b0},
        {2'd3, 3'd0, 8'h00, 8'h00, 1'b1, 2'b0},
        {2'd3, 3'd0, 8'h00, 8'h01, 1'b1, 2'b0},
        {2'd3, 3'd4, 8'h00, 8'h01, 1'b0, 2'b0},
        {2'd2, 3'd1, 8'hFE, 8'hFE, 1'b0, 2'b0},
        {2'd2, 3'd0, 8'h00, 8'hFF, 1'b0, 2'b0},
        {2'd2, 3'd0, 8'h00, 8'hFE, 1'b0, 2'b0},
        {2'd2, 3'd2, 8'h00, 8'h00, 1'b0, 2'b0},
        {2'd2, 3'd0, 8'h00, 8'h01, 1'b0, 2'b0},
        {2'd1, 3'd1, 8'hFE, 8'hFE, 1'b0, 2'b0},
        {2'd1, 3'd0, 8'h00, 8'hFF, 1'b0, 2'b0},
        {2'd1, 3'd0, 8'h00, 8'h00, 1'b0, 2'b0},
        {2'd1, 3'd0, 8'h00, 8'h01, 1'b0, 2'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] mode = 2'd0;
    logic       src_sel = 1'b0;
    logic       presc_tick = 1'b0;
    logic       ext_tick = 1'b0;
    logic       tmr_clr = 1'b0;
    logic [7:0] cnt;
    logic       at_top, at_bottom, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updown_tmr u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode(mode),
        .src_sel(src_sel), .presc_tick(presc_tick), .ext_tick(ext_tick),
        .tmr_clr(tmr_clr), .cnt(cnt), .at_top(at_top),
        .at_bottom(at_bottom), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; drives one cycle and returns at the next negedge
    task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] dt,
                       input logic c, input logic t);
        reg_wr = w; reg_addr = a; reg_wdata = dt; tmr_clr = c; presc_tick = t;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00; tmr_clr = 1'b0; presc_tick = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
        reg_addr = 2'd0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cnt", 32'(cnt), 32'h00);
        chk("R1 irq", 32'(irq), 32'h0);
        read_reg(2'd1, rv); chk("R1 compare", 32'(rv), 32'h00);
        read_reg(2'd2, rv); chk("R1 ctl", 32'(rv), 32'h00);
        chk("R5 at_bottom at reset", 32'(at_bottom), 32'h1);
        chk("R5 at_top at reset", 32'(at_top), 32'h0);

        // R2 R3 R4 R11 vector walk
        for (int i = 0; i < NV; i++) begin
            logic [7:0] dv;
            dv   = VEC[i][18:11];
            mode = VEC[i][23:22];
            case (VEC[i][21:19])
                3'd0: cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
                3'd1: cyc(1'b1, 2'd0, dv,    1'b0, 1'b0);
                3'd2: cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
                3'd3: cyc(1'b1, 2'd1, dv,    1'b0, 1'b0);
                default: cyc(1'b1, 2'd2, 8'h01, 1'b0, 1'b0);
            endcase
            chk($sformatf("R2/R3/R4/R11 vec%0d cnt", i), 32'(cnt), 32'(VEC[i][10:3]));
            read_reg(2'd2, rv);
            chk($sformatf("R2/R3/R4/R11 vec%0d flag", i), 32'(rv[0]), 32'(VEC[i][2]));
        end

        // R5 top indication follows selected TOP
        mode = 2'd1;
        cyc(1'b1, 2'd0, 8'h03, 1'b0, 1'b0);
        chk("R5 at_top compare", 32'(at_top), 32'h1);
        chk("R5 at_bottom nonzero", 32'(at_bottom), 32'h0);
        mode = 2'd0; #1;
        chk("R5 at_top fixed max", 32'(at_top), 32'h0);

        // R6 hold without tick
        repeat (3) cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        chk("R6 hold", 32'(cnt), 32'h03);

        // R7 priority
        cyc(1'b1, 2'd0, 8'h40, 1'b1, 1'b1);
        chk("R7 write beats clear and tick", 32'(cnt), 32'h40);
        cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1);
        chk("R7 clear beats tick", 32'(cnt), 32'h00);
        chk("R7 at_bottom after clear", 32'(at_bottom), 32'h1);

        // R8 set and clear in same cycle: set wins
        cyc(1'b1, 2'd0, 8'hFF, 1'b0, 1'b0);
        cyc(1'b1, 2'd2, 8'h01, 1'b0, 1'b1);
        chk("R8 wrap cnt", 32'(cnt), 32'h00);
        read_reg(2'd2, rv); chk("R8 set wins", 32'(rv[0]), 32'h1);
        cyc(1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
        read_reg(2'd2, rv); chk("R8 write zero keeps flag", 32'(rv[0]), 32'h1);
        chk("R9 irq off without enable", 32'(irq), 32'h0);

        // R9 interrupt gating
        cyc(1'b1, 2'd2, 8'h02, 1'b0, 1'b0);
        chk("R9 irq on", 32'(irq), 32'h1);
        cyc(1'b1, 2'd2, 8'h03, 1'b0, 1'b0);
        chk("R9 irq off after clear", 32'(irq), 32'h0);
        read_reg(2'd2, rv); chk("R12 ctl readback", 32'(rv), 32'h02);
        read_reg(2'd1, rv); chk("R12 compare readback", 32'(rv), 32'h03);
        read_reg(2'd0, rv); chk("R12 count readback", 32'(rv), 32'h00);

        // R10 external tick source
        src_sel = 1'b1;
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
        chk("R10 prescaler ignored", 32'(cnt), 32'h00);
        ext_tick = 1'b1;
        @(negedge clk); chk("R10 latency edge1", 32'(cnt), 32'h00);
        @(negedge clk); chk("R10 latency edge2", 32'(cnt), 32'h00);
        @(negedge clk); chk("R10 step at edge3", 32'(cnt), 32'h01);
        repeat (2) @(negedge clk);
        chk("R10 one step per edge", 32'(cnt), 32'h01);
        ext_tick = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 no step on fall", 32'(cnt), 32'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule